// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block produces the raster timing for a TFT panel: line sync, frame sync, a data-enable strobe and zero-based pixel and line coordinates of the active picture. A programmable divider derives a one-cycle pixel strobe from the system clock. It divides by 2 × (divider + 1), or it passes every cycle when the bypass input is set. All raster counters advance only on that strobe.

The timing is set by eight fields. The horizontal sync width, back porch, active width and front porch are each given as their pixel count minus one. The vertical sync width and the active height are given as their line count minus one. The vertical back and front porches are given as plain line counts and may be zero. The active width is always rounded up to a whole multiple of four pixels. Each sync output has its own inversion input, which makes that sync active-low.

Dropping the enable clears the divider and both counters and parks every output at its inactive level. Raising it again starts the scan at the first pixel of the sync pulse on the first line. The timing fields are meant to be changed only while the enable is low.

Top module: `lcd_sync_gen`

## Requirements
- R1: Every line starts with hsync active for hpw_m1+1 pixel strobes. A back porch of hbp_m1+1 pixels follows, then the active pixels, then a front porch of hfp_m1+1 pixels.
- R2: The active part of a line lasts (hact_m1+1) pixels rounded up to the next multiple of 4, which is the same as (hact_m1 with its two low bits set)+1.
- R3: Every frame starts with vsync active for vpw_m1+1 lines. A back porch of vbp lines follows, then vact_m1+1 active lines, then a front porch of vfp lines. Zero porches are allowed, and vsync changes only at the start of a line.
- R4: de is 1 only when the pixel lies inside both the active pixels and the active lines. There x is the zero-based pixel index in the line and y is the zero-based active line index. Outside that region x and y are 0.
- R5: With byp=0 and en=1, pix_ce is high for one cycle in every 2*(div+1) cycles.
- R6: With byp=1 and en=1, pix_ce is high on every cycle.
- R7: hsync is the line-sync-active level XOR inv_h, and vsync is the frame-sync-active level XOR inv_v. With the inversion input set, the sync is active-low.
- R8: While en=0, pix_ce=0, de=0, x=0, y=0, hsync=inv_h and vsync=inv_v. After en rises, the scan restarts at the first pixel of the first line, even if the previous frame was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the scan |
| byp | input | 1 | Pixel strobe on every cycle when set |
| div | input | DW | Divider value; the strobe period is 2*(div+1) cycles |
| inv_h | input | 1 | Makes hsync active-low |
| inv_v | input | 1 | Makes vsync active-low |
| hpw_m1 | input | HW | Line sync width minus 1 |
| hbp_m1 | input | HW | Horizontal back porch minus 1 |
| hact_m1 | input | HW | Active width minus 1, rounded up to a multiple of 4 pixels |
| hfp_m1 | input | HW | Horizontal front porch minus 1 |
| vpw_m1 | input | VW | Frame sync width in lines minus 1 |
| vbp | input | VW | Vertical back porch in lines, may be 0 |
| vact_m1 | input | VW | Active height minus 1 |
| vfp | input | VW | Vertical front porch in lines, may be 0 |
| pix_ce | output | 1 | One-cycle pixel strobe |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| x | output | HW | Active pixel index |
| y | output | VW | Active line index |

## Verification
The sync, de and coordinate outputs are decoded combinationally from the counters. Each pixel's values therefore appear right after the clock edge that advanced the counters and hold until the next strobe edge. pix_ce is decoded from the divider count, so it is high during the last cycle of each pixel. The bench samples at the falling edge of every cycle in which pix_ce is high. It compares each sample with the next pixel in a queue that the driver fills by walking the segment lengths. The bench also measures the spacing between strobes against the divider setting, and it checks the parked levels one falling edge after en drops.

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          byp,
  input  logic [DW-1:0] div,
  input  logic          inv_h,
  input  logic          inv_v,
  input  logic [HW-1:0] hpw_m1,
  input  logic [HW-1:0] hbp_m1,
  input  logic [HW-1:0] hact_m1,
  input  logic [HW-1:0] hfp_m1,
  input  logic [VW-1:0] vpw_m1,
  input  logic [VW-1:0] vbp,
  input  logic [VW-1:0] vact_m1,
  input  logic [VW-1:0] vfp,
  output logic          pix_ce,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] x,
  output logic [VW-1:0] y
);
  localparam int HCW = HW + 3;
  localparam int VCW = VW + 3;

  // pixel strobe divider
  logic [DW:0] dcnt;
  logic [DW:0] dlim;
  logic        dwrap;
  assign dlim   = {div, 1'b1};
  assign dwrap  = (dcnt == dlim);
  assign pix_ce = en & (byp | dwrap);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     dcnt <= '0;
    else if (!en || byp || dwrap)   dcnt <= '0;
    else                            dcnt <= dcnt + 1'b1;

  // segment boundaries
  logic [HCW-1:0] h_se, h_as, h_ae, h_tot, hcnt;
  logic [VCW-1:0] v_se, v_as, v_ae, v_tot, vcnt;
  assign h_se  = HCW'(hpw_m1) + HCW'(1);
  assign h_as  = h_se + HCW'(hbp_m1) + HCW'(1);
  assign h_ae  = h_as + HCW'({hact_m1[HW-1:2], 2'b11}) + HCW'(1);
  assign h_tot = h_ae + HCW'(hfp_m1) + HCW'(1);
  assign v_se  = VCW'(vpw_m1) + VCW'(1);
  assign v_as  = v_se + VCW'(vbp);
  assign v_ae  = v_as + VCW'(vact_m1) + VCW'(1);
  assign v_tot = v_ae + VCW'(vfp);

  logic h_last, v_last, h_act, v_act;
  assign h_last = (hcnt >= h_tot - HCW'(1));
  assign v_last = (vcnt >= v_tot - VCW'(1));
  assign h_act  = (hcnt >= h_as) && (hcnt < h_ae);
  assign v_act  = (vcnt >= v_as) && (vcnt < v_ae);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pix_ce) begin
      hcnt <= h_last ? '0 : hcnt + 1'b1;
      if (h_last) vcnt <= v_last ? '0 : vcnt + 1'b1;
    end

  assign hsync = (en & (hcnt < h_se)) ^ inv_h;
  assign vsync = (en & (vcnt < v_se)) ^ inv_v;
  assign de    = en & h_act & v_act;
  assign x     = de ? HW'(hcnt - h_as) : '0;
  assign y     = de ? VW'(vcnt - v_as) : '0;

  // R5: divided strobe never lasts two cycles
  p_ce_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !byp && pix_ce) |=> !pix_ce);

  // R1: no active pixel overlaps the line sync
  p_de_outside_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync == inv_h));

  // R3: frame sync moves only at a line start
  p_vs_line_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $stable(inv_v) && (vsync != $past(vsync))) |-> (hcnt == '0));

  // R4: x steps by one across consecutive active pixels
  p_x_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (de && pix_ce) |=> (!de || (x == HW'($past(x) + 1'b1))));

  // R8: dropping enable parks the scan at its origin
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> (hcnt == '0 && vcnt == '0 && !de && !pix_ce));
endmodule

// File: tb/test_lcd_sync_gen.sv
module test_lcd_sync_gen;
  localparam int P = 10;

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic       de;
    logic [9:0] x;
    logic [9:0] y;
  } item_t;

  logic clk = 0, rst_n = 0, en = 0, byp = 0, inv_h = 0, inv_v = 0;
  logic [7:0] div = 0;
  logic [9:0] hpw_m1 = 0, hbp_m1 = 0, hact_m1 = 0, hfp_m1 = 0;
  logic [9:0] vpw_m1 = 0, vbp = 0, vact_m1 = 0, vfp = 0;
  logic pix_ce, hsync, vsync, de;
  logic [9:0] x, y;

  int checks = 0, errors = 0, pushed = 0, cyc = 0, last_ce = 0;
  bit have_prev = 0, finished = 0;
  item_t q[$];

  lcd_sync_gen i_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .byp(byp), .div(div),
    .inv_h(inv_h), .inv_v(inv_v),
    .hpw_m1(hpw_m1), .hbp_m1(hbp_m1), .hact_m1(hact_m1), .hfp_m1(hfp_m1),
    .vpw_m1(vpw_m1), .vbp(vbp), .vact_m1(vact_m1), .vfp(vfp),
    .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y));

  always #(P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected pixel stream built from segment lengths (R1..R4, R7)
  task automatic push_frames(input int nf, input int lim);
    int hl[4], vl[4];
    hl[0] = hpw_m1 + 1; hl[1] = hbp_m1 + 1;
    hl[2] = ((hact_m1 + 1 + 3) / 4) * 4; hl[3] = hfp_m1 + 1;
    vl[0] = vpw_m1 + 1; vl[1] = vbp; vl[2] = vact_m1 + 1; vl[3] = vfp;
    pushed = 0;
    for (int f = 0; f < nf; f++)
      for (int vs = 0; vs < 4; vs++)
        for (int i = 0; i < vl[vs]; i++)
          for (int hs = 0; hs < 4; hs++)
            for (int j = 0; j < hl[hs]; j++) begin
              item_t it;
              it.hs = (hs == 0) ^ inv_h;
              it.vs = (vs == 0) ^ inv_v;
              it.de = (hs == 2) && (vs == 2);
              it.x  = it.de ? 10'(j) : 10'd0;
              it.y  = it.de ? 10'(i) : 10'd0;
              if (pushed < lim) begin
                q.push_back(it);
                pushed++;
              end
            end
  endtask

  task automatic run_until_empty;
    @(posedge clk); #(P/4) en = 1;
    while (q.size() != 0) @(posedge clk);
    #(P/4) en = 0;
  endtask

  task automatic check_idle;
    @(negedge clk);
    chk(pix_ce == 0, "R8 pix_ce idle", pix_ce, 0);
    chk(de == 0,     "R8 de idle", de, 0);
    chk(x == 0 && y == 0, "R8 coords idle", {x, y}, 0);
    chk(hsync == inv_h, "R8/R7 hsync idle", hsync, inv_h);
    chk(vsync == inv_v, "R8/R7 vsync idle", vsync, inv_v);
  endtask

  // monitor: one sample per pixel, on the falling edge of a strobe cycle
  always @(negedge clk) begin
    if (!en) have_prev = 0;
    else if (rst_n && pix_ce) begin
      if (have_prev)
        chk(cyc - last_ce == (byp ? 1 : 2 * (div + 1)),
            byp ? "R6 strobe gap" : "R5 strobe gap",
            cyc - last_ce, byp ? 1 : 2 * (div + 1));
      have_prev = 1;
      last_ce = cyc;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        chk(hsync == e.hs, "R1/R7 hsync", hsync, e.hs);
        chk(vsync == e.vs, "R3/R7 vsync", vsync, e.vs);
        chk(de == e.de,    "R4 de", de, e.de);
        chk(x == e.x,      "R2/R4 x", x, e.x);
        chk(y == e.y,      "R4 y", y, e.y);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(P/4) rst_n = 1;
    check_idle;                                     // R8 reset state

    // A: divide by 2, plain polarity, already aligned width
    div = 0; byp = 0;
    hpw_m1 = 1; hbp_m1 = 2; hact_m1 = 7; hfp_m1 = 1;
    vpw_m1 = 0; vbp = 0; vact_m1 = 2; vfp = 0;       // R3 zero porches
    push_frames(2, 1 << 30);
    run_until_empty;
    check_idle;

    // B: bypass, both syncs inverted, width 6 rounds to 8 (R2, R6, R7)
    byp = 1; inv_h = 1; inv_v = 1;
    hpw_m1 = 0; hbp_m1 = 0; hact_m1 = 5; hfp_m1 = 3;
    vpw_m1 = 1; vbp = 2; vact_m1 = 1; vfp = 1;
    check_idle;
    push_frames(2, 1 << 30);
    run_until_empty;
    check_idle;

    // C: divide by 6, width 9 rounds to 12, frame cut short then restarted (R8)
    byp = 0; div = 2; inv_h = 0; inv_v = 1;
    hpw_m1 = 2; hbp_m1 = 1; hact_m1 = 8; hfp_m1 = 0;
    vpw_m1 = 0; vbp = 1; vact_m1 = 1; vfp = 2;
    push_frames(1, 40);
    run_until_empty;
    check_idle;
    push_frames(1, 1 << 30);
    run_until_empty;
    check_idle;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(P * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule